// File: doc/BRIEF.md
# Instruction Memory Boot Loader

This block performs the cold-boot copy for a small Harvard-architecture processor. After reset, and if the boot switch is set, it walks the whole instruction address space. For each location it presents the address to a non-volatile program ROM, takes the returned byte and writes it into the same address of the instruction RAM. While it does this, it owns the instruction RAM bus and keeps the processor held in reset. After the last location has been written, it raises a done flag and drops the hold, and from then on the processor's own fetch path drives the RAM.

If the boot switch is clear when reset is released, no copy happens. The loader goes straight to its finished state, and the processor runs whatever the instruction RAM already contains. The finished state stays in force until the next reset, whatever the switch does in the meantime.

The reset input is asynchronous and active low. Its release passes through a small synchroniser, so every internal register leaves reset on a clock edge. Both memories are assumed to be synchronous. The ROM returns data one clock after it receives an address, and the RAM stores the write data on the clock edge that ends a cycle with the write strobe high.

Top module: `imem_boot_loader`

## Requirements
- R1: While reset is asserted, and in every cycle until the finished state is reached, `cpu_hold_o` is 1, `done_o` is 0 and `ram_we_o` is 0 during reset. `cpu_hold_o` falls only in the cycle in which `done_o` rises.
- R2: With the boot switch at 1 when the synchronised reset is released, every instruction RAM address 0x00..0xFF ends up holding the byte that the ROM holds at the same address.
- R3: With the boot switch at 0 when the synchronised reset is released, the loader performs no RAM write and reaches the finished state 3 clock edges after `rst_ni` rises (2 synchroniser edges plus 1 decision edge). The RAM keeps its previous contents.
- R4: During a copy, the write strobe is high for exactly one cycle per address. The writes target addresses 0x00, 0x01, ... 0xFF in ascending order, which gives 256 writes in total.
- R5: Each byte takes three cycles: address to ROM, write pulse, advance. The write to an address comes in the cycle directly after that address was driven to the ROM, and consecutive write pulses are exactly 3 cycles apart.
- R6: The finished state is sticky. Toggling the boot switch afterwards produces no write, keeps `done_o` at 1 and keeps `cpu_hold_o` at 0 until the next reset.
- R7: Asserting reset in the middle of a copy raises `cpu_hold_o` and clears `done_o` and `ram_we_o` at once, without waiting for a clock. The next boot starts again from address 0x00.
- R8: A full copy finishes, with `done_o` observed high, exactly 2 + 1 + 3x256 = 771 clock edges after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_sw_i | input | 1 | Boot switch: 1 requests a ROM-to-RAM copy after reset |
| rom_rdata_i | input | 8 | Byte returned by the ROM one clock after its address |
| rom_addr_o | output | 8 | ROM read address |
| ram_addr_o | output | 8 | Instruction RAM address while the loader owns the bus |
| ram_wdata_o | output | 8 | Instruction RAM write data |
| ram_we_o | output | 1 | Instruction RAM write strobe, one cycle per byte |
| cpu_hold_o | output | 1 | Holds the processor in reset; also selects the loader onto the RAM bus |
| done_o | output | 1 | Copy finished (or skipped); sticky until reset |

## Verification
The hardest situation to reach is a reset that lands in the middle of a copy: the RAM is then partly written and the address counter is somewhere past zero. The stimulus reaches it by letting a boot run for several hundred cycles and then dropping reset between clock edges. It checks the outputs right away, before the next edge, and then completes a fresh boot whose first write must target address 0x00. The skip path also needs a prepared state: the RAM must already hold a known image while the ROM holds a different random one, so that a stray write would become visible.

// File: rtl/bootld_pkg.sv
package bootld_pkg;

  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_READ  = 3'd1,
    LD_WRITE = 3'd2,
    LD_STEP  = 3'd3,
    LD_DONE  = 3'd4
  } ld_state_e;

endpackage

// File: rtl/bootld_rst_sync.sv
module bootld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  // Shift a constant 1 toward the output; assertion is immediate, release takes STAGES edges.
  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/bootld_addr_ctr.sv
module bootld_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  // Clock enable written out: the register only loads on clear or advance.
  assign addr_en = clr_i | inc_i;

  always_comb begin
    addr_d = addr_q;
    if (clr_i)      addr_d = '0;
    else if (inc_i) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;

endmodule

// File: rtl/bootld_fsm.sv
module bootld_fsm
  import bootld_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      boot_sw_i,
  input  logic      last_i,
  output ld_state_e state_o
);

  ld_state_e state_q;
  ld_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE:  state_d = boot_sw_i ? LD_READ : LD_DONE;
      LD_READ:  state_d = LD_WRITE;
      LD_WRITE: state_d = LD_STEP;
      LD_STEP:  state_d = last_i ? LD_DONE : LD_READ;
      LD_DONE:  state_d = LD_DONE;
      default:  state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LD_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/imem_boot_loader.sv
module imem_boot_loader
  import bootld_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_sw_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_we_o,
  output logic              cpu_hold_o,
  output logic              done_o
);

  logic              rst_sync_n;
  ld_state_e         state;
  logic [ADDR_W-1:0] addr;
  logic              addr_last;
  logic              addr_clr;
  logic              addr_inc;

  bootld_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  bootld_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .boot_sw_i (boot_sw_i),
    .last_i    (addr_last),
    .state_o   (state)
  );

  assign addr_clr = (state == LD_IDLE);
  assign addr_inc = (state == LD_STEP);

  bootld_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (addr_clr),
    .inc_i  (addr_inc),
    .addr_o (addr),
    .last_o (addr_last)
  );

  // The ROM and the RAM see the same index; the RAM write uses the ROM byte returned one cycle later.
  assign rom_addr_o  = addr;
  assign ram_addr_o  = addr;
  assign ram_wdata_o = rom_rdata_i;
  assign ram_we_o    = (state == LD_WRITE);
  assign done_o      = (state == LD_DONE);
  assign cpu_hold_o  = (state != LD_DONE);

endmodule

// File: rtl/imem_boot_loader_chk.sv
module imem_boot_loader_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              cpu_hold_o,
  input logic              done_o
);

  logic [ADDR_W-1:0] prev_wr_q;
  logic              have_wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_wr_q <= '0;
      have_wr_q <= 1'b0;
    end else if (ram_we_o) begin
      prev_wr_q <= ram_addr_o;
      have_wr_q <= 1'b1;
    end
  end

  a_r1_hold_drops_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_hold_o) |-> done_o);

  a_r1_hold_before_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> cpu_hold_o);

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  a_r4_ascending_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && have_wr_q) |-> (ram_addr_o == prev_wr_q + 1'b1));

  a_r5_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_addr_o == $past(rom_addr_o)));

  a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r6_no_write_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ram_we_o);

endmodule

bind imem_boot_loader imem_boot_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rom_addr_o (rom_addr_o),
  .ram_addr_o (ram_addr_o),
  .ram_we_o   (ram_we_o),
  .cpu_hold_o (cpu_hold_o),
  .done_o     (done_o)
);

// File: tb/imem_boot_loader_test.sv
module imem_boot_loader_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int DW         = 8;
  localparam int DEPTH      = 1 << AW;
  localparam int SYNC       = 2;
  localparam int SEED       = 32'h1B00_7A5E;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_sw = 1'b1;
  logic [DW-1:0] rom_q = '0;
  logic [AW-1:0] rom_addr, ram_addr;
  logic [DW-1:0] ram_wdata;
  logic          ram_we, cpu_hold, done;

  logic [DW-1:0] rom_mem [DEPTH];
  logic [DW-1:0] ram_mem [DEPTH];
  logic [DW-1:0] old_img [DEPTH];

  int nchk = 0;
  int nfail = 0;
  int mon_writes = 0;
  int mon_bad = 0;
  int exp_addr = 0;
  int gap = 0;
  bit seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imem_boot_loader #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYNC)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .boot_sw_i   (boot_sw),
    .rom_rdata_i (rom_q),
    .rom_addr_o  (rom_addr),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .ram_we_o    (ram_we),
    .cpu_hold_o  (cpu_hold),
    .done_o      (done)
  );

  // Synchronous memory models.
  always @(posedge clk) rom_q <= rom_mem[rom_addr];
  always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= ram_wdata;

  // Write-order monitor (R4, R5): ascending addresses, pulses 3 cycles apart.
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_addr = 0;
      gap = 0;
      seen = 0;
    end else begin
      gap++;
      if (ram_we) begin
        if (int'(ram_addr) != exp_addr) begin
          mon_bad++;
          $display("monitor: write addr %0d, expected %0d", ram_addr, exp_addr);
        end
        if (seen && gap != 3) begin
          mon_bad++;
          $display("monitor: write spacing %0d, expected 3", gap);
        end
        seen = 1;
        gap = 0;
        exp_addr++;
        mon_writes++;
      end
    end
  end

  function automatic int exp_boot_cycles(input bit sw);
    return SYNC + 1 + (sw ? 3 * DEPTH : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input bit sw);
    @(negedge clk);
    rst_n = 1'b0;
    boot_sw = sw;
    repeat (3) @(negedge clk);
    chk(cpu_hold == 1'b1, "R1", "hold in reset", cpu_hold, 1);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(ram_we == 1'b0, "R1", "we in reset", ram_we, 0);
  endtask

  // Releases reset on a falling edge and counts rising edges until done is seen.
  task automatic release_and_wait(output int cycles);
    int n = 0;
    bit hold_err = 0;
    rst_n = 1'b1;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (!done && !cpu_hold) hold_err = 1;
    end
    chk(hold_err == 0, "R1", "hold dropped early", hold_err, 0);
    chk(cpu_hold == 1'b0, "R1", "hold after done", cpu_hold, 0);
    cycles = n;
  endtask

  task automatic fill_rom(input int mode);
    for (int i = 0; i < DEPTH; i++) begin
      case (mode)
        0:       rom_mem[i] = DW'($urandom);
        1:       rom_mem[i] = DW'(i ^ 8'hA5);
        default: rom_mem[i] = (i[0]) ? '1 : '0;
      endcase
    end
  endtask

  task automatic compare_ram(input string req, input bit use_old);
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] want;
      want = use_old ? old_img[i] : rom_mem[i];
      chk(ram_mem[i] === want, req, $sformatf("ram[%0d]", i), int'(ram_mem[i]), int'(want));
    end
  endtask

  task automatic full_boot(input int mode);
    int cyc, w0, b0;
    fill_rom(mode);
    apply_reset(1'b1);
    w0 = mon_writes;
    b0 = mon_bad;
    release_and_wait(cyc);
    chk(cyc == exp_boot_cycles(1'b1), "R8", "boot cycles", cyc, exp_boot_cycles(1'b1));
    chk(mon_writes - w0 == DEPTH, "R4", "write count", mon_writes - w0, DEPTH);
    chk(mon_bad == b0, "R5", "order/spacing errors", mon_bad - b0, 0);
    @(negedge clk);
    compare_ram("R2", 1'b0);
  endtask

  initial begin
    int dummy, cyc, w0, b0, bad;
    dummy = $urandom(SEED);

    // Boot with random image.
    full_boot(0);

    // R6: sticky finished state under switch toggling.
    w0 = mon_writes;
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      boot_sw = 1'($urandom);
      if (!done || cpu_hold) bad++;
    end
    chk(bad == 0, "R6", "done/hold changed", bad, 0);
    chk(mon_writes == w0, "R6", "writes after done", mon_writes - w0, 0);

    // R3: skip path keeps the old RAM image.
    for (int i = 0; i < DEPTH; i++) old_img[i] = ram_mem[i];
    fill_rom(0);
    apply_reset(1'b0);
    w0 = mon_writes;
    release_and_wait(cyc);
    chk(cyc == exp_boot_cycles(1'b0), "R3", "skip cycles", cyc, exp_boot_cycles(1'b0));
    chk(mon_writes == w0, "R3", "writes on skip", mon_writes - w0, 0);
    compare_ram("R3", 1'b1);

    // R7: reset in the middle of a copy.
    fill_rom(1);
    apply_reset(1'b1);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk(cpu_hold == 1'b1, "R7", "hold on async reset", cpu_hold, 1);
    chk(done == 1'b0, "R7", "done on async reset", done, 0);
    chk(ram_we == 1'b0, "R7", "we on async reset", ram_we, 0);
    repeat (3) @(negedge clk);
    w0 = mon_writes;
    b0 = mon_bad;
    release_and_wait(cyc);
    chk(cyc == exp_boot_cycles(1'b1), "R7", "restart cycles", cyc, exp_boot_cycles(1'b1));
    chk(mon_writes - w0 == DEPTH, "R7", "restart write count", mon_writes - w0, DEPTH);
    chk(mon_bad == b0, "R7", "restart starts at 0", mon_bad - b0, 0);
    @(negedge clk);
    compare_ram("R7", 1'b0);

    // Directed alternating image.
    full_boot(2);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

endmodule